// File: doc/BRIEF.md
# Configurable Registered/Combinational Output Cell

This block is one output stage of a sum-of-products logic array. It receives the OR-sum of the product terms that belong to it, a shared clock, a global clear term, a global set term and a private drive-enable term. A two-bit configuration word decides whether the sum is stored in a D flip-flop or passed straight through, and whether the pad level is the true or inverted value. The cell presents a pad drive value and drive enable to an external tri-state buffer, senses the pad level back, and returns one feedback bit to the array.

Global clear and set act on the stored bit, ahead of the polarity stage, so the pad level they produce depends on the selected polarity. An active-low power-on input clears the stored bit asynchronously. For test, a load strobe writes the sensed pad level into the flip-flop on the next edge; a lock bit blocks that path once the cell's content is to be protected.

Top module: `sop_out_cell`

## Requirements
- R1: `cfgMode[1]` picks the path (0 = stored, 1 = pass-through) and `cfgMode[0]` the polarity (0 = inverted, 1 = true); the all-zero word, as left by an erased cell, is stored with inverted polarity.
- R2: In stored mode the flip-flop takes `sumTerm` on each rising clock edge and the pad value changes only after that edge.
- R3: In pass-through mode `padOut` follows `sumTerm` with no clock edge needed.
- R4: With `cfgMode[0]` = 0, `padOut` is the complement of the stored bit (stored mode) or of `sumTerm` (pass-through mode).
- R5: While `arTerm` is 1 the stored bit is 0 at once, without a clock edge; the pad shows that 0 through the polarity stage.
- R6: A 1 on `spTerm` sets the stored bit to 1 at the next rising edge and not earlier.
- R7: Priority on the stored bit is `arTerm` above `spTerm` above `sumTerm`.
- R8: `arrayFb` is the stored bit, before polarity, in stored mode and the sensed pad `padIn` in pass-through mode.
- R9: `padOe` equals `oeTerm`; with it at 0 the pad is undriven, and a pass-through cell with a never-enabled driver works as an input through `arrayFb`.
- R10: A 0 on `porN` clears the stored bit at once; after power-on an inverted stored cell therefore drives 1.
- R11: With `secureLock` at 0, `preloadStb` at 1 loads `padIn` into the flip-flop at the next edge, taking precedence over `spTerm` and `sumTerm` but not over `arTerm`.
- R12: With `secureLock` at 1, `preloadStb` has no effect and the flip-flop takes its normal next value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared array clock, rising edge |
| porN | input | 1 | Power-on clear, active low, asynchronous |
| sumTerm | input | 1 | OR-sum of this cell's product terms |
| arTerm | input | 1 | Global asynchronous clear term |
| spTerm | input | 1 | Global synchronous set term |
| oeTerm | input | 1 | Drive-enable product term |
| cfgMode | input | 2 | Bit 1 path select, bit 0 polarity select |
| secureLock | input | 1 | 1 blocks the test load path |
| preloadStb | input | 1 | Test load strobe |
| padIn | input | 1 | Level sensed at the pad |
| padOut | output | 1 | Value to drive onto the pad |
| padOe | output | 1 | Pad driver enable |
| arrayFb | output | 1 | Feedback bit to the array |

## Verification
The bench aims at the places where the ordering of controls on the stored bit matters: clear held across an edge together with set, set together with a test load, and a test load with the lock applied; a design with priorities swapped would leave a 1 where a 0 is due, or the reverse. It checks the pad both just before and just after an edge, so a cell that let `sumTerm` leak straight to the pad in stored mode, or that waited for a clock to honour clear, shows a wrong level at one of the two samples. Feedback is checked with the pad sense set opposite to the sum, so a cell that fed back the wrong source, or fed back after the polarity stage, returns the wrong bit.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

  localparam int CFG_W = 2;

  typedef enum logic [CFG_W-1:0] {
    MODE_STORED_INV  = 2'b00,
    MODE_STORED_TRUE = 2'b01,
    MODE_PASS_INV    = 2'b10,
    MODE_PASS_TRUE   = 2'b11
  } cell_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrN;       // asynchronous clear of the flip-flop, active low
    logic setNext;    // load 1 on next edge
    logic loadPad;    // load pad sense on next edge
    logic storedPath; // 1: pad and feedback use the flip-flop
    logic trueLevel;  // 1: no inversion at the pad
  } cell_strobe_t;

endpackage

// File: rtl/sop_cell_ctrl.sv
module sop_cell_ctrl
  import sop_cell_pkg::*;
(
  input  logic             porN,
  input  logic             arTerm,
  input  logic             spTerm,
  input  logic [CFG_W-1:0] cfgMode,
  input  logic             secureLock,
  input  logic             preloadStb,
  output cell_strobe_t     strobe
);

  cell_mode_e mode;
  assign mode = cell_mode_e'(cfgMode);

  always_comb begin
    strobe.clrN    = porN & ~arTerm;
    strobe.loadPad = preloadStb & ~secureLock;
    strobe.setNext = spTerm;
    unique case (mode)
      MODE_STORED_INV:  begin strobe.storedPath = 1'b1; strobe.trueLevel = 1'b0; end
      MODE_STORED_TRUE: begin strobe.storedPath = 1'b1; strobe.trueLevel = 1'b1; end
      MODE_PASS_INV:    begin strobe.storedPath = 1'b0; strobe.trueLevel = 1'b0; end
      default:          begin strobe.storedPath = 1'b0; strobe.trueLevel = 1'b1; end
    endcase
  end

endmodule

// File: rtl/sop_cell_dp.sv
module sop_cell_dp
  import sop_cell_pkg::*;
(
  input  logic         clk,
  input  cell_strobe_t strobe,
  input  logic         sumTerm,
  input  logic         oeTerm,
  input  logic         padIn,
  output logic         flopQ,
  output logic         padOut,
  output logic         padOe,
  output logic         arrayFb
);

  logic clrN;
  logic coreVal;
  assign clrN = strobe.clrN;

  // Priority: clear, test load, set, sum
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)                flopQ <= 1'b0;
    else if (strobe.loadPad)  flopQ <= padIn;
    else if (strobe.setNext)  flopQ <= 1'b1;
    else                      flopQ <= sumTerm;
  end

  always_comb begin
    coreVal = strobe.storedPath ? flopQ : sumTerm;
    padOut  = strobe.trueLevel ? coreVal : ~coreVal;
    arrayFb = strobe.storedPath ? flopQ : padIn;
    padOe   = oeTerm;
  end

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
  import sop_cell_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  logic             sumTerm,
  input  logic             arTerm,
  input  logic             spTerm,
  input  logic             oeTerm,
  input  logic [CFG_W-1:0] cfgMode,
  input  logic             secureLock,
  input  logic             preloadStb,
  input  logic             padIn,
  output logic             padOut,
  output logic             padOe,
  output logic             arrayFb
);

  cell_strobe_t strobe;
  logic         flopQ;

  sop_cell_ctrl u_ctrl (
    .porN(porN), .arTerm(arTerm), .spTerm(spTerm), .cfgMode(cfgMode),
    .secureLock(secureLock), .preloadStb(preloadStb), .strobe(strobe)
  );

  sop_cell_dp u_dp (
    .clk(clk), .strobe(strobe), .sumTerm(sumTerm), .oeTerm(oeTerm),
    .padIn(padIn), .flopQ(flopQ), .padOut(padOut), .padOe(padOe),
    .arrayFb(arrayFb)
  );

endmodule

// File: rtl/sop_out_cell_chk.sv
module sop_out_cell_chk
  import sop_cell_pkg::*;
(
  input logic             clk,
  input logic             porN,
  input logic             sumTerm,
  input logic             arTerm,
  input logic             spTerm,
  input logic [CFG_W-1:0] cfgMode,
  input logic             secureLock,
  input logic             preloadStb,
  input logic             padIn,
  input logic             flopQ,
  input logic             arrayFb
);

  assert_async_clear_R5: assert property (@(posedge clk) disable iff (!porN)
    arTerm |-> !flopQ);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!porN)
    (!arTerm && !spTerm && !preloadStb) |=> (arTerm || flopQ == $past(sumTerm)));

  assert_preset_R6: assert property (@(posedge clk) disable iff (!porN)
    (!arTerm && spTerm && !(preloadStb && !secureLock)) |=> (arTerm || flopQ));

  assert_preload_R11: assert property (@(posedge clk) disable iff (!porN)
    (!arTerm && preloadStb && !secureLock) |=> (arTerm || flopQ == $past(padIn)));

  assert_locked_R12: assert property (@(posedge clk) disable iff (!porN)
    (!arTerm && !spTerm && preloadStb && secureLock) |=> (arTerm || flopQ == $past(sumTerm)));

  assert_fb_pass_R8: assert property (@(posedge clk) disable iff (!porN)
    cfgMode[1] |-> (arrayFb == padIn));

  assert_fb_stored_R8: assert property (@(posedge clk) disable iff (!porN)
    !cfgMode[1] |-> (arrayFb == flopQ));

endmodule

bind sop_out_cell sop_out_cell_chk u_chk (.*);

// File: tb/sop_out_cell_bench.sv
module sop_out_cell_bench;

  logic       clk = 1'b0;
  logic       porN, sumTerm, arTerm, spTerm, oeTerm, secureLock, preloadStb, padIn;
  logic [1:0] cfgMode;
  logic       padOut, padOe, arrayFb;
  int         nVec = 0;
  int         nBad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sop_out_cell u_sop_out_cell (
    .clk(clk), .porN(porN), .sumTerm(sumTerm), .arTerm(arTerm), .spTerm(spTerm),
    .oeTerm(oeTerm), .cfgMode(cfgMode), .secureLock(secureLock),
    .preloadStb(preloadStb), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .arrayFb(arrayFb)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %b want %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive on falling edge, sample 1 ns after the rising edge
  task automatic edgeStep();
    @(posedge clk); #1;
  endtask

  task automatic t_power_on();
    porN = 0; sumTerm = 0; arTerm = 0; spTerm = 0; oeTerm = 0;
    cfgMode = 2'b00; secureLock = 0; preloadStb = 0; padIn = 0;
    #12;
    chk("R10 power-on inverted pad", padOut, 1'b1);
    chk("R1 erased word stored path fb", arrayFb, 1'b0);
    @(negedge clk); porN = 1;
  endtask

  task automatic t_stored();
    @(negedge clk); cfgMode = 2'b01; sumTerm = 1; #1;
    chk("R2 no change before edge", padOut, 1'b0);
    edgeStep();
    chk("R2 capture 1", padOut, 1'b1);
    chk("R8 stored fb", arrayFb, 1'b1);
    @(negedge clk); sumTerm = 0; edgeStep();
    chk("R2 capture 0", padOut, 1'b0);
    @(negedge clk); cfgMode = 2'b00; sumTerm = 1; edgeStep();
    chk("R4 stored inverted pad", padOut, 1'b0);
    chk("R8 fb before polarity", arrayFb, 1'b1);
  endtask

  task automatic t_pass();
    @(negedge clk); cfgMode = 2'b11; sumTerm = 0; padIn = 1; #1;
    chk("R3 pass 0", padOut, 1'b0);
    chk("R8 pass fb from pad", arrayFb, 1'b1);
    sumTerm = 1; #1;
    chk("R3 pass 1 no edge", padOut, 1'b1);
    cfgMode = 2'b10; #1;
    chk("R4 pass inverted", padOut, 1'b0);
    oeTerm = 1; #1;
    chk("R9 enable on", padOe, 1'b1);
    oeTerm = 0; padIn = 0; #1;
    chk("R9 enable off", padOe, 1'b0);
    chk("R9 dedicated input", arrayFb, 1'b0);
  endtask

  task automatic t_clear();
    @(negedge clk); cfgMode = 2'b01; sumTerm = 1; edgeStep();
    #2 arTerm = 1; #1;
    chk("R5 clear without edge", padOut, 1'b0);
    @(negedge clk); spTerm = 1; edgeStep();
    chk("R7 clear over set", padOut, 1'b0);
    @(negedge clk); arTerm = 0; cfgMode = 2'b00; #1;
    chk("R5 cleared bit inverted pad", padOut, 1'b1);
    edgeStep();
    chk("R7 set over sum-less", arrayFb, 1'b1);
    @(negedge clk); spTerm = 0;
  endtask

  task automatic t_preset();
    @(negedge clk); cfgMode = 2'b01; sumTerm = 0; edgeStep();
    chk("R6 setup low", padOut, 1'b0);
    @(negedge clk); spTerm = 1; #1;
    chk("R6 not before edge", padOut, 1'b0);
    edgeStep();
    chk("R6 set at edge / R7 over sum", padOut, 1'b1);
    @(negedge clk); spTerm = 0; edgeStep();
    chk("R2 sum resumes", padOut, 1'b0);
  endtask

  task automatic t_preload();
    @(negedge clk); cfgMode = 2'b01; sumTerm = 0; padIn = 1; preloadStb = 1; edgeStep();
    chk("R11 load pad 1", padOut, 1'b1);
    @(negedge clk); padIn = 0; spTerm = 1; edgeStep();
    chk("R11 load over set", padOut, 1'b0);
    @(negedge clk); spTerm = 0; secureLock = 1; padIn = 1; edgeStep();
    chk("R12 locked load ignored", padOut, 1'b0);
    @(negedge clk); preloadStb = 0; secureLock = 0; padIn = 0;
  endtask

  task automatic t_por_mid();
    @(negedge clk); cfgMode = 2'b01; sumTerm = 1; edgeStep();
    chk("R10 pre", padOut, 1'b1);
    #2 porN = 0; #1;
    chk("R10 async clear", padOut, 1'b0);
    @(negedge clk); porN = 1;
  endtask

  initial begin
    t_power_on();
    t_stored();
    t_pass();
    t_clear();
    t_preset();
    t_preload();
    t_por_mid();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      nVec++; nBad++;
      $display("FAIL watchdog: got timeout want completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule